// File: doc/BRIEF.md
# Byte-Wide SPI Slave with Guarded Transmit Loading

This block is the receiving end of an SPI link. It runs entirely on the system clock. The serial clock, data-in and select pins pass through synchronizer flops, and the block finds serial clock edges by comparing successive synchronized samples. Clock polarity and phase are set by two configuration inputs, so all four SPI modes are covered. Words are `DW` bits wide (8 by default) and travel most significant bit first in both directions.

Firmware talks to the block through strobes. A write strobe fills a one-word transmit holding register. A read strobe for received data and a read strobe for status each clear their own flags. Four flags are driven continuously: transmit holding empty, receive holding full, word complete, and overrun.

The holding word moves into the output shift register only when three things are true: no transfer is in progress, the shifter holds nothing, and the holding register has data. When no word was loaded, the data output shifts out ones.

The select can come from the external pin. A configuration input can instead hand it to a firmware-driven bit. Whenever the select is inactive (high), the shift machinery is held in reset and the data output sits at 1.

Top module: `spis_slave`

## Requirements
- R1: While the effective select is high, `miso_o` is 1 and serial clock or data activity on the pins completes no word and changes no flag.
- R2: With `cfg_ss_internal`=1 the effective select is `cfg_ss_bit_n` and the `ss_n_i` pin is ignored; with 0 the select is the pin.
- R3: Raising the select in the middle of a word discards the partial word. The next transfer starts again from bit 0 and produces the correct word.
- R4: Idle serial clock level equals `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the leading edge and changed on the trailing edge. With `cfg_cpha`=1, data is changed on the leading edge and sampled on the trailing edge. Both directions are MSB first, and a finished word appears on `rx_data_o`.
- R5: The holding word is loaded into the shifter only when there is no transfer in progress, the shifter is empty and the holding register has data. A word written during a transfer waits.
- R6: With `cfg_cpha`=0, a transfer is in progress from the select falling (or from a leading edge while the select is already low) until its last bit is sampled. A load may happen at the select fall or in any cycle after a completion while the select stays low.
- R7: With `cfg_cpha`=1, the load happens on the leading edge of the first bit of a transfer, so data written after the select falls but before that edge is still sent.
- R8: A transfer with no word loaded shifts out all ones.
- R9: `tx_empty_o` goes to 0 on a write strobe and back to 1 when the word is loaded into the shifter.
- R10: A completed word sets `rx_full_o` and `xfer_done_o`. `rd_rx_i` clears `rx_full_o` only; `rd_stat_i` clears `rx_full_o`, `xfer_done_o` and `overrun_o`.
- R11: A word completing while `rx_full_o` is 1 sets `overrun_o` and replaces `rx_data_o` with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_ss_internal | input | 1 | Select comes from `cfg_ss_bit_n` instead of the pin |
| cfg_ss_bit_n | input | 1 | Firmware select bit, active low |
| sclk_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Select pin, active low |
| miso_o | output | 1 | Serial data out |
| wr_tx_i | input | 1 | Write strobe for the transmit holding register |
| wr_data_i | input | DW | Transmit word |
| rd_rx_i | input | 1 | Received-data read strobe |
| rd_stat_i | input | 1 | Status read strobe |
| rx_data_o | output | DW | Last received word |
| tx_empty_o | output | 1 | Transmit holding register empty |
| rx_full_o | output | 1 | Unread received word present |
| xfer_done_o | output | 1 | A word completed since the last status read |
| overrun_o | output | 1 | A word arrived while the previous was unread |

## Verification
A bit counter left at a wrong value shows up within one word: `rx_data_o` is rotated or `xfer_done_o` comes too early or too late. This is most exposed after a transfer is cut off by the select. A load made at the wrong moment shows up at `miso_o` on the very next sampled bit: either all ones where data was expected, or data one transfer early. A wrong flag update is visible a single system clock after the completing edge or the strobe.

// File: rtl/spis_pkg.sv
package spis_pkg;

  // Internal clock view: polarity removed, so 0->1 is always the leading edge.
  function automatic logic edge_lead(input logic prev_s, input logic cur_s, input logic pol);
    return ((prev_s ^ pol) == 1'b0) && ((cur_s ^ pol) == 1'b1);
  endfunction

  function automatic logic edge_trail(input logic prev_s, input logic cur_s, input logic pol);
    return ((prev_s ^ pol) == 1'b1) && ((cur_s ^ pol) == 1'b0);
  endfunction

  // Sampling edge selection by phase.
  function automatic logic is_sample(input logic lead, input logic trail, input logic pha);
    return pha ? trail : lead;
  endfunction

  function automatic logic is_launch(input logic lead, input logic trail, input logic pha);
    return pha ? lead : trail;
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spis_shifter.sv
module spis_shifter
  import spis_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          ss_act,
  input  logic          tx_pending,
  input  logic [DW-1:0] tx_word,
  output logic          load_evt,
  output logic          byte_done,
  output logic [DW-1:0] rx_word,
  output logic          miso_bit
);

  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sclk_q, ss_q;
  logic          busy, loaded;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rxs, txs;

  // Named internal events
  logic lead, trail, samp, launch, ss_start, start_evt, samp_act, load_win;

  assign lead      = edge_lead(sclk_q, sclk_s, cpol);
  assign trail     = edge_trail(sclk_q, sclk_s, cpol);
  assign samp      = is_sample(lead, trail, cpha);
  assign launch    = is_launch(lead, trail, cpha);
  assign ss_start  = ss_act & ~ss_q;

  // Transfer start: phase 0 begins at select fall or at a leading edge while idle;
  // phase 1 begins at the leading edge of its first bit.
  assign start_evt = ss_act & ~busy & (cpha ? lead : (ss_start | lead));
  assign samp_act  = ss_act & samp & (busy | start_evt);
  assign byte_done = samp_act & (cnt == LAST);

  // Load window: outside a transfer; phase 1 only on the first leading edge.
  assign load_win  = ss_act & ~busy & (cpha ? lead : 1'b1);
  assign load_evt  = load_win & ~loaded & tx_pending;

  assign rx_word   = {rxs[DW-2:0], mosi_s};
  assign miso_bit  = txs[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      loaded <= 1'b0;
      cnt    <= '0;
      rxs    <= '0;
      txs    <= '1;
    end else if (!ss_act) begin
      busy   <= 1'b0;
      loaded <= 1'b0;
      cnt    <= '0;
      rxs    <= '0;
      txs    <= '1;
    end else if (byte_done) begin
      busy   <= 1'b0;
      loaded <= 1'b0;
      cnt    <= '0;
      rxs    <= '0;
      txs    <= '1;
    end else begin
      if (start_evt) busy <= 1'b1;
      if (samp_act) begin
        rxs <= rx_word;
        cnt <= cnt + 1'b1;
      end
      if (load_evt) begin
        txs    <= tx_word;
        loaded <= 1'b1;
      end else if (launch && busy) begin
        txs <= {txs[DW-2:0], 1'b1};
      end
    end
  end

  // R3: a negated select leaves the machine idle at bit 0
  a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> (cnt == '0) && !busy && !loaded);

  // R8: with nothing loaded the output shifter can only hold ones
  a_r8_empty_is_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (txs == '1));

endmodule

// File: rtl/spis_regs.sv
module spis_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_rx,
  input  logic          rd_stat,
  input  logic          load_evt,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] tx_word,
  output logic          tx_pending,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          done,
  output logic          ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word    <= '0;
      tx_pending <= 1'b0;
      rx_data    <= '0;
      rx_full    <= 1'b0;
      done       <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      if (wr_tx) tx_word <= wr_data;
      // A write in the load cycle keeps the new word pending.
      if (wr_tx)         tx_pending <= 1'b1;
      else if (load_evt) tx_pending <= 1'b0;

      if (byte_done) rx_data <= rx_word;

      if (byte_done)            rx_full <= 1'b1;
      else if (rd_rx | rd_stat) rx_full <= 1'b0;

      if (byte_done)    done <= 1'b1;
      else if (rd_stat) done <= 1'b0;

      if (byte_done && rx_full) ovr <= 1'b1;
      else if (rd_stat)         ovr <= 1'b0;
    end
  end

  // R9: a load without a competing write empties the holding register
  a_r9_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !wr_tx |=> !tx_pending);

  // R10: completion raises both flags on the next cycle
  a_r10_flags_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_full && done);

  // R11: completion over an unread word raises overrun
  a_r11_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_full |=> ovr);

endmodule

// File: rtl/spis_slave.sv
module spis_slave #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_ss_internal,
  input  logic          cfg_ss_bit_n,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          ss_n_i,
  output logic          miso_o,
  input  logic          wr_tx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_rx_i,
  input  logic          rd_stat_i,
  output logic [DW-1:0] rx_data_o,
  output logic          tx_empty_o,
  output logic          rx_full_o,
  output logic          xfer_done_o,
  output logic          overrun_o
);

  logic [2:0]    pins_s;
  logic          sclk_s, mosi_s, ss_pin_s, ss_act;
  logic          load_evt, byte_done, miso_bit, tx_pending;
  logic [DW-1:0] tx_word, rx_word;

  // Bit order {select, data, clock}; select resets to inactive.
  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({ss_n_i, mosi_i, sclk_i}),
    .q_o  (pins_s)
  );

  assign sclk_s   = pins_s[0];
  assign mosi_s   = pins_s[1];
  assign ss_pin_s = pins_s[2];
  assign ss_act   = ~(cfg_ss_internal ? cfg_ss_bit_n : ss_pin_s);

  spis_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .ss_act    (ss_act),
    .tx_pending(tx_pending),
    .tx_word   (tx_word),
    .load_evt  (load_evt),
    .byte_done (byte_done),
    .rx_word   (rx_word),
    .miso_bit  (miso_bit)
  );

  spis_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_tx     (wr_tx_i),
    .wr_data   (wr_data_i),
    .rd_rx     (rd_rx_i),
    .rd_stat   (rd_stat_i),
    .load_evt  (load_evt),
    .byte_done (byte_done),
    .rx_word   (rx_word),
    .tx_word   (tx_word),
    .tx_pending(tx_pending),
    .rx_data   (rx_data_o),
    .rx_full   (rx_full_o),
    .done      (xfer_done_o),
    .ovr       (overrun_o)
  );

  assign miso_o     = ss_act ? miso_bit : 1'b1;
  assign tx_empty_o = ~tx_pending;

  // R1: a deselected slave neither completes nor loads
  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |-> !byte_done && !load_evt);

  // R1: flags do not rise while deselected
  a_r1_no_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act && !rx_full_o |=> !rx_full_o);

endmodule

// File: tb/spis_slave_tb.sv
`timescale 1ns/100ps
module spis_slave_tb;
  localparam int DW = 8;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, ss_int = 0, ss_bit_n = 1;
  logic sclk = 0, mosi = 0, ss_n = 1;
  logic wr_tx = 0, rd_rx = 0, rd_stat = 0;
  logic [DW-1:0] wr_data = '0;
  logic miso, tx_empty, rx_full, done, ovr;
  logic [DW-1:0] rx_data;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spis_slave #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_ss_internal(ss_int), .cfg_ss_bit_n(ss_bit_n),
    .sclk_i(sclk), .mosi_i(mosi), .ss_n_i(ss_n), .miso_o(miso),
    .wr_tx_i(wr_tx), .wr_data_i(wr_data), .rd_rx_i(rd_rx), .rd_stat_i(rd_stat),
    .rx_data_o(rx_data), .tx_empty_o(tx_empty), .rx_full_o(rx_full),
    .xfer_done_o(done), .overrun_o(ovr)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [DW-1:0] d);
    wr_data = d; wr_tx = 1; tick(1); wr_tx = 0;
  endtask

  task automatic read_stat();
    rd_stat = 1; tick(1); rd_stat = 0;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cpol = pol; cpha = pha; sclk = pol; tick(4);
  endtask

  // Master side of one word; returns what the master sampled.
  task automatic xfer(input logic [DW-1:0] m, output logic [DW-1:0] s);
    for (int i = DW - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = m[i]; tick(H);
        s[i] = miso; sclk = ~cpol; tick(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = m[i]; tick(H);
        s[i] = miso; sclk = cpol; tick(H);
      end
    end
    tick(H);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] got, d, m;
    tick(3); rst_n = 1; tick(2);
    // Reset state
    chk("R1 reset miso", miso, 1);
    chk("R9 reset tx_empty", tx_empty, 1);
    chk("R10 reset rx_full", rx_full, 0);
    chk("R10 reset done", done, 0);
    chk("R11 reset overrun", ovr, 0);

    // Sweep all four modes and several words (R4, R5, R9, R10)
    for (int md = 0; md < 4; md++) begin
      for (int p = 0; p < 4; p++) begin
        set_mode(md[1], md[0]);
        d = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'(8'hA5 ^ (p * 8'h3B) ^ md);
        m = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'(p * 8'h55 + md * 8'h11);
        write_tx(d);
        chk("R9 tx_empty after write", tx_empty, 0);
        ss_n = 0; tick(8);
        // phase 0 loads at select fall, phase 1 waits for the first leading edge
        chk("R6/R7 load timing", tx_empty, cpha ? 1'b0 : 1'b1);
        xfer(m, got);
        chk("R4 slave word out", got, d);
        chk("R4 master word in", rx_data, m);
        chk("R9 tx_empty after load", tx_empty, 1);
        chk("R10 rx_full set", rx_full, 1);
        chk("R10 done set", done, 1);
        read_stat();
        chk("R10 rx_full cleared by status", rx_full, 0);
        chk("R10 done cleared by status", done, 0);
        ss_n = 1; tick(6);
        chk("R1 miso idle", miso, 1);
      end
    end

    // R8: no data pending -> all ones
    set_mode(0, 1);
    ss_n = 0; tick(6);
    xfer(8'h5A, got);
    chk("R8 all ones", got, 8'hFF);
    read_stat(); ss_n = 1; tick(6);

    // R5/R6: phase 0, write after select fall waits; then loaded in the gap while select held
    set_mode(0, 0);
    ss_n = 0; tick(8);
    write_tx(8'h3C);
    xfer(8'h11, got);
    chk("R5 late write not sent", got, 8'hFF);
    chk("R6 loaded after completion", tx_empty, 1);
    xfer(8'h22, got);
    chk("R6 held select next word", got, 8'h3C);
    // R10: rd_rx clears rx_full only; R11 overrun from two unread words
    chk("R11 overrun set", ovr, 1);
    chk("R11 newest word kept", rx_data, 8'h22);
    rd_rx = 1; tick(1); rd_rx = 0;
    chk("R10 rd_rx clears full", rx_full, 0);
    chk("R10 rd_rx keeps done", done, 1);
    chk("R10 rd_rx keeps overrun", ovr, 1);
    read_stat();
    chk("R11 overrun cleared", ovr, 0);
    ss_n = 1; tick(6);

    // R7: phase 1, write after select fall before first edge is still sent
    set_mode(1, 1);
    ss_n = 0; tick(8);
    write_tx(8'hC3);
    xfer(8'h81, got);
    chk("R7 late write sent", got, 8'hC3);
    read_stat(); ss_n = 1; tick(6);

    // R1: activity while deselected is ignored
    set_mode(0, 0);
    for (int i = 0; i < 2 * DW; i++) begin
      mosi = i[0]; sclk = ~sclk; tick(H);
      if (miso !== 1'b1) chk("R1 miso while deselected", miso, 1);
    end
    sclk = 0; tick(4);
    chk("R1 no word while deselected", rx_full, 0);
    chk("R1 no done while deselected", done, 0);

    // R3: abort mid-word then clean transfer
    write_tx(8'h96);
    ss_n = 0; tick(8);
    for (int i = 0; i < 4; i++) begin
      mosi = 1; tick(H); sclk = 1; tick(H); sclk = 0;
    end
    ss_n = 1; tick(6);
    chk("R3 miso after abort", miso, 1);
    chk("R3 no word after abort", rx_full, 0);
    write_tx(8'h69);
    ss_n = 0; tick(8);
    xfer(8'h4D, got);
    chk("R3 word after abort out", got, 8'h69);
    chk("R3 word after abort in", rx_data, 8'h4D);
    read_stat(); ss_n = 1; tick(6);

    // R2: internal select, pin stays high; two words with held select (phase 1)
    set_mode(1, 1);
    ss_int = 1; ss_bit_n = 1;
    write_tx(8'hE7);
    ss_bit_n = 0; tick(6);
    xfer(8'h18, got);
    chk("R2 internal select word out", got, 8'hE7);
    chk("R2 internal select word in", rx_data, 8'h18);
    write_tx(8'h5B);
    tick(4);
    xfer(8'h24, got);
    chk("R7 held select second word", got, 8'h5B);
    read_stat();
    ss_bit_n = 1; tick(4);
    chk("R2 internal deselect miso", miso, 1);
    // Pin low but internal source deselected: nothing happens
    ss_n = 0; tick(6);
    xfer(8'h77, got);
    chk("R2 pin ignored", rx_full, 0);
    ss_n = 1; ss_int = 0; tick(6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule